// File: doc/BRIEF.md
# Four-Function Select-Coded ALU

This block is a small arithmetic-logic unit for two unsigned operands, X and Y, each `W` bits wide (default 4). A 2-bit operation code picks one of four functions. Two are arithmetic: the sum X + Y, or the difference X - Y. Two are comparisons: whether X equals Y, or whether Y is strictly larger than X. All four select codes are in use. Every function writes the same `W+1`-bit result word. For arithmetic, the low `W` bits hold the data value and the top bit holds the carry (for addition) or the borrow (for subtraction). For a comparison, the boolean answer goes in bit 0 and every other bit is zero.

Addition and subtraction share one ripple adder. For subtraction the adder inverts Y and forces the carry-in to 1. A separate comparator produces the equality and magnitude flags. A result multiplexer, steered by the decoded operation, assembles the word. The word is then captured in an output register that has a synchronous active-high reset. A caller sees the result one clock after it presents the inputs.

Top module: `alu_quad`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res` becomes all zeros, whatever `sel`, `x` and `y` hold.
- R2: With `sel` = 2'b10 (add), `res` = {carry, (x + y) mod 2^W}, where carry is 1 exactly when x + y is at least 2^W.
- R3: With `sel` = 2'b11 (subtract), `res[W-1:0]` = (x - y) mod 2^W in two's complement.
- R4: With `sel` = 2'b11, `res[W]` is the borrow: 1 exactly when y > x as unsigned values.
- R5: With `sel` = 2'b00 (equality), `res[0]` = 1 exactly when x == y, and `res[W:1]` are zero.
- R6: With `sel` = 2'b01 (greater-than), `res[0]` = 1 exactly when y > x unsigned, equal operands give 0, and `res[W:1]` are zero.
- R7: The result for the inputs sampled at one rising edge appears on `res` right after that edge, for every one of the 1024 combinations of `sel`, `x` and `y` at W = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| sel | input | 2 | Operation code: 00 equal, 01 Y greater than X, 10 add, 11 subtract |
| x | input | W | First operand, unsigned |
| y | input | W | Second operand, unsigned |
| res | output | W+1 | Registered result word: data bits plus carry/borrow in the top bit |

## Verification
On every cycle, the assertions check four things. First, the reset clears the register. Second, an addition or subtraction lands on `res` one edge after its operands were sampled. Third, the upper bits stay zero after either comparison. Fourth, the adder's borrow in subtract mode agrees with the comparator's greater-than flag, even though the two flags come from separate logic. Other properties need the bench: the exact result value for every select and operand combination, and the behaviour at the boundaries (wrap-around on overflow, underflow to a borrow, equal operands under the greater-than test). The bench shows these by walking a table of corner vectors and then sweeping all 1024 input combinations against its own arithmetic.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  typedef enum logic [1:0] {
    OP_EQ  = 2'b00,
    OP_GT  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0]   carry;
  logic [W-1:0] b_eff;

  assign b_eff    = b ^ {W{sub}};
  assign carry[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
  end

  assign cout = carry[W];
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         b_gt_a
);
  assign eq     = (a == b);
  assign b_gt_a = (b > a);
endmodule

// File: rtl/alu_resmux.sv
module alu_resmux #(
  parameter int W = 4
) (
  input  alu4_pkg::op_e op,
  input  logic [W-1:0]  sum,
  input  logic          cout,
  input  logic          eq,
  input  logic          b_gt_a,
  output logic [W:0]    word
);
  import alu4_pkg::*;

  always_comb begin
    unique case (op)
      OP_ADD:  word = {cout, sum};
      OP_SUB:  word = {~cout, sum};
      OP_EQ:   word = {{W{1'b0}}, eq};
      default: word = {{W{1'b0}}, b_gt_a};
    endcase
  end
endmodule

// File: rtl/alu_quad.sv
module alu_quad #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   res
);
  import alu4_pkg::*;

  localparam int RW = W + 1;

  op_e           op;
  logic          is_sub;
  logic [W-1:0]  sum;
  logic          cout;
  logic          eq;
  logic          y_gt_x;
  logic [RW-1:0] word;

  assign op     = op_e'(sel);
  assign is_sub = (op == OP_SUB);

  alu_addsub #(.W(W)) u_addsub (
    .a(x), .b(y), .sub(is_sub), .sum(sum), .cout(cout)
  );

  alu_cmp #(.W(W)) u_cmp (
    .a(x), .b(y), .eq(eq), .b_gt_a(y_gt_x)
  );

  alu_resmux #(.W(W)) u_mux (
    .op(op), .sum(sum), .cout(cout), .eq(eq), .b_gt_a(y_gt_x), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else     res <= word;
  end

  // R1: reset clears the register
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> res == '0);

  // R2: sum and carry land one edge after the operands
  p_add_result_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == 2'b10) |->
      res == ({1'b0, $past(x)} + {1'b0, $past(y)}));

  // R3: wrapped difference lands one edge after the operands
  p_sub_result_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) == 2'b11) |->
      res[W-1:0] == W'($past(x) - $past(y)));

  // R4: adder borrow agrees with the independent comparator
  p_borrow_matches_gt_r4: assert property (@(posedge clk) disable iff (rst)
    is_sub |-> (~cout == y_gt_x));

  // R5, R6: upper bits are zero after a comparison
  p_cmp_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel[1]) == 1'b0) |-> res[W:1] == '0);

  // R6: equality and greater-than never both hold
  p_eq_gt_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(eq && y_gt_x));
endmodule

// File: tb/tb_alu_quad.sv
`timescale 1ns/1ps
module tb_alu_quad;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sel = '0;
  logic [W-1:0] x = '0;
  logic [W-1:0] y = '0;
  logic [W:0]   res;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alu_quad #(.W(W)) dut (.clk(clk), .rst(rst), .sel(sel), .x(x), .y(y), .res(res));

  // {sel, x, y, expected}
  localparam logic [14:0] VEC [12] = '{
    {2'b10, 4'h0, 4'h1, 5'b00001},   // R2 plain add
    {2'b10, 4'hF, 4'h1, 5'b10000},   // R2 carry, zero data
    {2'b10, 4'hF, 4'hF, 5'b11110},   // R2 max + max
    {2'b11, 4'h1, 4'h0, 5'b00001},   // R3 plain subtract
    {2'b11, 4'h0, 4'h1, 5'b11111},   // R3/R4 underflow
    {2'b11, 4'h1, 4'hF, 5'b10010},   // R4 borrow, wrap to 2
    {2'b11, 4'h7, 4'h7, 5'b00000},   // R4 equal, no borrow
    {2'b00, 4'h4, 4'h4, 5'b00001},   // R5 equal
    {2'b00, 4'h0, 4'h4, 5'b00000},   // R5 not equal
    {2'b01, 4'h7, 4'hF, 5'b00001},   // R6 y greater
    {2'b01, 4'hF, 4'hC, 5'b00000},   // R6 x greater
    {2'b01, 4'h9, 4'h9, 5'b00000}    // R6 equal gives 0
  };

  function automatic logic [W:0] model(input logic [1:0] s, input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    int ia = int'(a);
    int ib = int'(b);
    case (s)
      2'b10:   return (W+1)'(ia + ib);
      2'b11:   return {ib > ia, W'(ia - ib)};
      2'b00:   return (W+1)'(ia == ib);
      default: return (W+1)'(ib > ia);
    endcase
  endfunction

  function automatic string tag(input logic [1:0] s);
    case (s)
      2'b10:   return "R2";
      2'b11:   return "R3/R4";
      2'b00:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: res=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    sel = s; x = a; y = b;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset clears and ignores inputs
    sel = 2'b10; x = 4'hF; y = 4'hF;
    @(negedge clk); @(negedge clk);
    check("R1 reset state", res, '0);
    sel = 2'b11; x = 4'h0; y = 4'h5;
    @(negedge clk);
    check("R1 inputs ignored in reset", res, '0);
    rst = 1'b0;

    // table of corner vectors
    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][14:13], VEC[i][12:9], VEC[i][8:5]);
      check({tag(VEC[i][14:13]), " table"}, res, VEC[i][4:0]);
    end

    // R1: reset from a nonzero result
    apply(2'b10, 4'hF, 4'hF);
    check("R2 before reset", res, 5'b11110);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 clear from nonzero", res, '0);
    rst = 1'b0;

    // R7: exhaustive sweep, one-clock latency
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          apply(2'(s), 4'(a), 4'(b));
          check({tag(2'(s)), " R7 sweep"}, res, model(2'(s), 4'(a), 4'(b)));
        end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: res=%b expected=finish", res);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule